// File: doc/BRIEF.md
# I2S Master Serial Port with Selectable Justification

This block is the master end of a two-channel serial audio link. It derives a bit clock from its own clock at half rate, drives a word-select line with an even duty cycle, shifts a left and a right transmit word out MSb first and shifts two receive words in from the serial input. Both edges of word select open a new word. Word select low carries the left channel and high carries the right channel.

The half-frame length (bit-clock periods per channel) and the word size are set separately. A justification input picks between the standard placement, where the MSb follows the word-select edge by one bit period, and the edge-aligned placement, where the MSb appears in the bit period that word select changes in. Outside the bits of a word the serial output enable is dropped. The host side presents both transmit words as plain inputs and reads both received words from plain outputs. A one-cycle interrupt strobe marks each complete stereo frame.

The output changes on the falling edge of the bit clock and the input is sampled on the rising edge. Configuration and transmit words are taken at the start of each frame, so a change in the middle of a frame does not tear it.

Top module: `i2s_master_port`

## Requirements
- R1: While `en` is high the bit clock `sck` toggles on every rising edge of `clk`. The first edge that sees `en` high drives it high, and the next edge drives it low to open the first bit period. A bit period runs from one falling edge of `sck` to the next.
- R2: `ws` is low for the left word and high for the right word. Each level lasts exactly the latched half-frame length in bit periods, and `ws` changes only at a falling edge of `sck`. The first bit period after enable is slot 0 of a left half.
- R3: With `cfg_msb_align` = 0, the bit sent in slot k of a half (slot 0 starts at the `ws` change) is bit (W-1-(k-1)) of the word, for k from 1 to W, where W is the effective word size. Data is MSb first and changes at `sck` falling edges.
- R4: With `cfg_msb_align` = 1, the bit sent in slot k is bit (W-1-k) of the word, for k from 0 to W-1. The MSb therefore shares its falling `sck` edge with the `ws` change.
- R5: `sdo_oe` is high exactly during the data slots named in R3/R4 and low in all other slots. `sdo` reads 0 whenever `sdo_oe` is low.
- R6: `sdi` is sampled on the rising `sck` edge of each data slot of the same window as transmit, MSb first. Bits in the other slots are ignored. The received word appears in the low W bits of its output, with the upper bits zero.
- R7: At the falling `sck` edge that starts a frame, if a full left and right half ran before it since enable, `frame_irq` is high for one `clk` cycle. `rx_left` and `rx_right` take the new words on that same edge and hold them otherwise.
- R8: `tx_left` and `tx_right` are both sampled at the `sck` falling edge that starts a frame (`ws` going to, or starting at, left). They are used for that frame.
- R9: `cfg_half_len`, `cfg_word_len` and `cfg_msb_align` are sampled only at a frame start. A change at any other time takes effect at the next frame.
- R10: The half-frame length is clamped to 8..32. The word size is clamped to 4..16 and then to the data window: half length minus 1 when `cfg_msb_align` = 0, the half length when it is 1.
- R11: During reset or while `en` is low, `sck`, `ws`, `sdo`, `sdo_oe` and `frame_irq` are 0. Reset also clears `rx_left` and `rx_right`. After re-enable, a new frame starts at slot 0 of a left half and no strobe comes before a full frame has run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the bit clock runs at half its rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the link idle |
| cfg_half_len | input | 6 | Bit periods per half frame (clamped 8..32) |
| cfg_word_len | input | 5 | Word size in bits (clamped 4..16 and to the window) |
| cfg_msb_align | input | 1 | 0: MSb one bit period after `ws` edge; 1: MSb at the edge |
| tx_left | input | 16 | Left transmit word, low bits used |
| tx_right | input | 16 | Right transmit word, low bits used |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select, 0 left / 1 right |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo`; low means released |
| sdi | input | 1 | Serial data in |
| rx_left | output | 16 | Last received left word |
| rx_right | output | 16 | Last received right word |
| frame_irq | output | 1 | One-cycle strobe per complete stereo frame |

## Verification
The bench builds the block with its default parameters: half frames of 8 to 32 bit periods and words of 4 to 16 bits. These defaults make the shortest and longest half frames reachable. They also make the case where the word fills the whole window in either justification reachable. Out-of-range settings on both fields test the clamps. Because random settings change in the middle of frames, the bench also tests that configuration and transmit words are taken only at a frame start.

// File: rtl/i2s_port_pkg.sv
package i2s_port_pkg;

  // Placement of the first data bit relative to the word-select change.
  typedef enum logic {
    JUST_DELAYED = 1'b0,
    JUST_AT_EDGE = 1'b1
  } just_e;

endpackage

// File: rtl/i2s_frame_timer.sv
module i2s_frame_timer
  import i2s_port_pkg::*;
#(
  parameter int HALF_MIN = 8,
  parameter int HALF_MAX = 32,
  parameter int WORD_MIN = 4,
  parameter int WORD_MAX = 16,
  localparam int HW = $clog2(HALF_MAX + 1),
  localparam int WW = $clog2(WORD_MAX + 1),
  localparam int IW = $clog2(WORD_MAX),
  localparam int CW = (HW > WW) ? HW : WW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [HW-1:0] cfg_half,
  input  logic [WW-1:0] cfg_word,
  input  logic          cfg_just,
  output logic          sck,
  output logic          ws,
  output logic [HW-1:0] slot_cnt,
  output logic          just_cur,
  output logic          slot_edge,
  output logic          half_start,
  output logic          frame_start,
  output logic          first_slot,
  output logic          ws_next,
  output logic          bit_valid,
  output logic [IW-1:0] bit_idx,
  output logic          rx_take
);

  logic          run_q, run_n, sck_q, sck_n, ws_q, ws_n, first_q, first_n;
  logic [HW-1:0] cnt_q, cnt_n, hlen_q, hlen_n, half_c, win_c;
  logic [WW-1:0] wlen_q, wlen_n, word_c, word_e;
  logic          just_q, just_n, hs, fs;

  // Slot c lies inside the data window of a word of w bits.
  function automatic logic in_win(input logic [HW-1:0] c, input logic j,
                                  input logic [WW-1:0] w);
    logic [CW:0] d;
    if (!j && c == '0) return 1'b0;
    d = (CW+1)'(c) - (CW+1)'(!j);
    return d < (CW+1)'(w);
  endfunction

  // Word bit sent in slot c, MSb first.
  function automatic logic [IW-1:0] msb_idx(input logic [HW-1:0] c, input logic j,
                                            input logic [WW-1:0] w);
    logic [CW:0] d;
    d = (CW+1)'(c) - (CW+1)'(!j);
    return IW'((CW+1)'(w) - d - (CW+1)'(1));
  endfunction

  // Clamp the requested sizes into the legal ranges and the data window.
  always_comb begin
    if (cfg_half < HW'(HALF_MIN))      half_c = HW'(HALF_MIN);
    else if (cfg_half > HW'(HALF_MAX)) half_c = HW'(HALF_MAX);
    else                               half_c = cfg_half;
    win_c = (cfg_just == JUST_AT_EDGE) ? half_c : half_c - HW'(1);
    if (cfg_word < WW'(WORD_MIN))      word_c = WW'(WORD_MIN);
    else if (cfg_word > WW'(WORD_MAX)) word_c = WW'(WORD_MAX);
    else                               word_c = cfg_word;
    if (CW'(word_c) > CW'(win_c)) word_e = WW'(win_c);
    else                          word_e = word_c;
  end

  // Next-state logic: start, rising and falling bit-clock phases.
  always_comb begin
    run_n   = run_q;
    sck_n   = sck_q;
    ws_n    = ws_q;
    first_n = first_q;
    cnt_n   = cnt_q;
    hlen_n  = hlen_q;
    wlen_n  = wlen_q;
    just_n  = just_q;
    hs      = 1'b0;
    fs      = 1'b0;
    if (!en) begin
      run_n   = 1'b0;
      sck_n   = 1'b0;
      ws_n    = 1'b0;
      first_n = 1'b0;
      cnt_n   = '0;
    end else if (!run_q) begin
      run_n   = 1'b1;
      sck_n   = 1'b1;
      first_n = 1'b1;
    end else if (!sck_q) begin
      sck_n = 1'b1;
    end else begin
      sck_n = 1'b0;
      if (first_q) begin
        cnt_n   = '0;
        ws_n    = 1'b0;
        first_n = 1'b0;
        hs      = 1'b1;
        fs      = 1'b1;
      end else if (cnt_q == hlen_q - HW'(1)) begin
        cnt_n = '0;
        ws_n  = ~ws_q;
        hs    = 1'b1;
        fs    = ws_q;
      end else begin
        cnt_n = cnt_q + HW'(1);
      end
    end
    if (fs) begin
      hlen_n = half_c;
      wlen_n = word_e;
      just_n = cfg_just;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      sck_q   <= 1'b0;
      ws_q    <= 1'b0;
      first_q <= 1'b0;
      cnt_q   <= '0;
      hlen_q  <= HW'(HALF_MIN);
      wlen_q  <= WW'(WORD_MIN);
      just_q  <= 1'b0;
    end else begin
      run_q   <= run_n;
      sck_q   <= sck_n;
      ws_q    <= ws_n;
      first_q <= first_n;
      cnt_q   <= cnt_n;
      hlen_q  <= hlen_n;
      wlen_q  <= wlen_n;
      just_q  <= just_n;
    end
  end

  assign sck         = sck_q;
  assign ws          = ws_q;
  assign slot_cnt    = cnt_q;
  assign just_cur    = just_q;
  assign slot_edge   = en & run_q & sck_q;
  assign half_start  = hs;
  assign frame_start = fs;
  assign first_slot  = first_q;
  assign ws_next     = ws_n;
  assign bit_valid   = in_win(cnt_n, just_n, wlen_n);
  assign bit_idx     = msb_idx(cnt_n, just_n, wlen_n);
  assign rx_take     = en & run_q & ~sck_q & in_win(cnt_q, just_q, wlen_q);

  assert_sck_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> (sck_q != $past(sck_q)));

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < hlen_q));

  assert_ws_at_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && (ws_q != $past(ws_q))) |-> (cnt_q == '0));

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 || ws_q) |-> ($stable(hlen_q) && $stable(wlen_q) && $stable(just_q)));

  assert_word_in_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (CW'(wlen_q) + CW'(!just_q)) <= CW'(hlen_q));

endmodule

// File: rtl/i2s_tx_path.sv
module i2s_tx_path #(
  parameter int WORD_MAX = 16,
  localparam int IW = $clog2(WORD_MAX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                slot_edge,
  input  logic                half_start,
  input  logic                frame_start,
  input  logic                ws_next,
  input  logic                bit_valid,
  input  logic [IW-1:0]       bit_idx,
  input  logic [WORD_MAX-1:0] tx_left,
  input  logic [WORD_MAX-1:0] tx_right,
  output logic                sdo,
  output logic                sdo_oe
);

  logic [WORD_MAX-1:0] word_q, word_n, hold_q, hold_n;
  logic                sdo_q, sdo_n, oe_q, oe_n;

  always_comb begin
    word_n = word_q;
    hold_n = hold_q;
    sdo_n  = sdo_q;
    oe_n   = oe_q;
    if (!en) begin
      sdo_n = 1'b0;
      oe_n  = 1'b0;
    end else if (slot_edge) begin
      if (frame_start) begin
        word_n = tx_left;
        hold_n = tx_right;
      end else if (half_start && ws_next) begin
        word_n = hold_q;
      end
      oe_n  = bit_valid;
      sdo_n = bit_valid & word_n[bit_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      hold_q <= '0;
      sdo_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      word_q <= word_n;
      hold_q <= hold_n;
      sdo_q  <= sdo_n;
      oe_q   <= oe_n;
    end
  end

  assign sdo    = sdo_q;
  assign sdo_oe = oe_q;

  assert_quiet_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> !sdo_q);

  assert_oe_on_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && en && !$stable(oe_q)) |-> $past(slot_edge));

endmodule

// File: rtl/i2s_rx_path.sv
module i2s_rx_path #(
  parameter int WORD_MAX = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                take,
  input  logic                sdi,
  input  logic                slot_edge,
  input  logic                half_start,
  input  logic                first_slot,
  input  logic                ws_cur,
  output logic [WORD_MAX-1:0] rx_left,
  output logic [WORD_MAX-1:0] rx_right,
  output logic                irq
);

  logic [WORD_MAX-1:0] sh_q, sh_n, lh_q, lh_n, rl_q, rl_n, rr_q, rr_n;
  logic                irq_q, irq_n;

  always_comb begin
    sh_n  = sh_q;
    lh_n  = lh_q;
    rl_n  = rl_q;
    rr_n  = rr_q;
    irq_n = 1'b0;
    if (!en) begin
      sh_n = '0;
    end else begin
      if (take) sh_n = {sh_q[WORD_MAX-2:0], sdi};
      if (slot_edge && half_start) begin
        sh_n = '0;
        if (!first_slot) begin
          if (!ws_cur) begin
            lh_n = sh_q;
          end else begin
            rl_n  = lh_q;
            rr_n  = sh_q;
            irq_n = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      lh_q  <= '0;
      rl_q  <= '0;
      rr_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      sh_q  <= sh_n;
      lh_q  <= lh_n;
      rl_q  <= rl_n;
      rr_q  <= rr_n;
      irq_q <= irq_n;
    end
  end

  assign rx_left  = rl_q;
  assign rx_right = rr_q;
  assign irq      = irq_q;

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(slot_edge && half_start && ws_cur && !first_slot));

  assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q |-> ($stable(rl_q) && $stable(rr_q)));

endmodule

// File: rtl/i2s_master_port.sv
module i2s_master_port #(
  parameter int HALF_MIN = 8,
  parameter int HALF_MAX = 32,
  parameter int WORD_MIN = 4,
  parameter int WORD_MAX = 16,
  localparam int HW = $clog2(HALF_MAX + 1),
  localparam int WW = $clog2(WORD_MAX + 1),
  localparam int IW = $clog2(WORD_MAX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [HW-1:0]       cfg_half_len,
  input  logic [WW-1:0]       cfg_word_len,
  input  logic                cfg_msb_align,
  input  logic [WORD_MAX-1:0] tx_left,
  input  logic [WORD_MAX-1:0] tx_right,
  output logic                sck,
  output logic                ws,
  output logic                sdo,
  output logic                sdo_oe,
  input  logic                sdi,
  output logic [WORD_MAX-1:0] rx_left,
  output logic [WORD_MAX-1:0] rx_right,
  output logic                frame_irq
);

  logic [HW-1:0] slot_cnt;
  logic [IW-1:0] bit_idx;
  logic just_cur, slot_edge, half_start, frame_start, first_slot, ws_next;
  logic bit_valid, rx_take;

  i2s_frame_timer #(
    .HALF_MIN(HALF_MIN), .HALF_MAX(HALF_MAX),
    .WORD_MIN(WORD_MIN), .WORD_MAX(WORD_MAX)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_half(cfg_half_len), .cfg_word(cfg_word_len), .cfg_just(cfg_msb_align),
    .sck(sck), .ws(ws), .slot_cnt(slot_cnt), .just_cur(just_cur),
    .slot_edge(slot_edge), .half_start(half_start), .frame_start(frame_start),
    .first_slot(first_slot), .ws_next(ws_next),
    .bit_valid(bit_valid), .bit_idx(bit_idx), .rx_take(rx_take)
  );

  i2s_tx_path #(.WORD_MAX(WORD_MAX)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(en),
    .slot_edge(slot_edge), .half_start(half_start), .frame_start(frame_start),
    .ws_next(ws_next), .bit_valid(bit_valid), .bit_idx(bit_idx),
    .tx_left(tx_left), .tx_right(tx_right),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  i2s_rx_path #(.WORD_MAX(WORD_MAX)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(en),
    .take(rx_take), .sdi(sdi),
    .slot_edge(slot_edge), .half_start(half_start), .first_slot(first_slot),
    .ws_cur(ws),
    .rx_left(rx_left), .rx_right(rx_right), .irq(frame_irq)
  );

  assert_delayed_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sdo_oe) && !just_cur) |-> (slot_cnt == HW'(1)));

  assert_edge_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sdo_oe) && just_cur) |-> (slot_cnt == '0));

  assert_idle_lines_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (!sck && !ws && !sdo_oe && !frame_irq));

endmodule

// File: tb/i2s_master_port_test.sv
module i2s_master_port_test;

  logic        clk = 1'b0;
  logic        rst_n, en, cfg_msb_align, sdi;
  logic [5:0]  cfg_half_len;
  logic [4:0]  cfg_word_len;
  logic [15:0] tx_left, tx_right, rx_left, rx_right;
  logic        sck, ws, sdo, sdo_oe, frame_irq;

  always #10 clk = ~clk;

  i2s_master_port uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_half_len(cfg_half_len), .cfg_word_len(cfg_word_len),
    .cfg_msb_align(cfg_msb_align),
    .tx_left(tx_left), .tx_right(tx_right),
    .sck(sck), .ws(ws), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi),
    .rx_left(rx_left), .rx_right(rx_right), .frame_irq(frame_irq)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int clamp_half(input int v);
    if (v < 8) return 8;
    if (v > 32) return 32;
    return v;
  endfunction

  function automatic int eff_word(input int w, input int h, input bit a);
    int x, win;
    x = (w < 4) ? 4 : ((w > 16) ? 16 : w);
    win = a ? h : h - 1;
    return (x > win) ? win : x;
  endfunction

  function automatic logic [15:0] low_bits(input logic [15:0] v, input int n);
    logic [15:0] m;
    m = 16'((32'd1 << n) - 1);
    return v & m;
  endfunction

  // Inputs as the design saw them at the last rising clk edge.
  logic s_rst, s_en, s_al;
  logic [5:0] s_half;
  logic [4:0] s_word;
  logic [15:0] s_tl, s_tr;
  always @(posedge clk) begin
    s_rst = rst_n; s_en = en; s_al = cfg_msb_align;
    s_half = cfg_half_len; s_word = cfg_word_len;
    s_tl = tx_left; s_tr = tx_right;
  end

  // Bench model of the link.
  logic prev_sck = 1'b0;
  bit   b_first = 1'b1;
  int   k = 0, h = 0, hl = 8, wl = 4;
  bit   al = 1'b0;
  logic [15:0] tl = '0, tr = '0, sent = '0, exp_l = '0, exp_r = '0;

  task automatic slot_event();
    bit newframe, newhalf, valid;
    int d;
    logic ebit;
    newframe = 1'b0; newhalf = 1'b0;
    if (b_first) begin
      k = 0; h = 0; newframe = 1'b1; newhalf = 1'b1;
    end else begin
      k++;
      if (k == hl) begin
        k = 0; h ^= 1; newhalf = 1'b1; newframe = (h == 0);
      end
    end
    if (newhalf && !b_first) begin
      if (h == 1) exp_l = low_bits(sent, wl);
      else        exp_r = low_bits(sent, wl);
    end
    if (newframe && !b_first) begin
      check(frame_irq == 1'b1, "R7 strobe at frame start", frame_irq, 1);
      check(rx_left == exp_l, "R6 R7 rx_left word", rx_left, exp_l);
      check(rx_right == exp_r, "R6 R7 rx_right word", rx_right, exp_r);
    end else begin
      check(frame_irq == 1'b0, "R7 R11 no strobe inside frame", frame_irq, 0);
    end
    if (newframe) begin
      // R8 R9 R10: words and settings taken at the frame start only.
      hl = clamp_half(int'(s_half));
      al = s_al;
      wl = eff_word(int'(s_word), hl, al);
      tl = s_tl; tr = s_tr;
    end
    if (newhalf) sent = 16'($urandom);
    b_first = 1'b0;
    check(ws == h[0], "R2 word select level", ws, h);
    d = k - (al ? 0 : 1);
    valid = (al || k != 0) && (d < wl);
    ebit = valid ? (h ? tr[wl-1-d] : tl[wl-1-d]) : 1'b0;
    check(sdo_oe == valid, "R5 R10 output enable window", sdo_oe, valid);
    check(sdo == ebit, al ? "R4 R8 R9 serial bit" : "R3 R8 R9 serial bit", sdo, ebit);
    sdi = valid ? sent[wl-1-d] : 1'($urandom);
  endtask

  always @(negedge clk) begin
    if (!s_rst || !s_en) begin
      if (s_rst)
        check(!sck && !ws && !sdo_oe && !sdo && !frame_irq, "R11 idle lines",
              {sck, ws, sdo_oe, sdo, frame_irq}, 0);
      b_first = 1'b1;
    end else begin
      check(sck != prev_sck, "R1 bit clock toggle", sck, !prev_sck);
      if (prev_sck && !sck) slot_event();
      else check(frame_irq == 1'b0, "R7 strobe only at slot edge", frame_irq, 0);
    end
    prev_sck = sck;
  end

  // Transmit words change at random times, often mid-frame.
  initial begin
    forever begin
      @(posedge clk); #4;
      if ($urandom % 9 == 0) tx_left = 16'($urandom);
      if ($urandom % 9 == 0) tx_right = 16'($urandom);
    end
  end

  task automatic run_cfg(input int hf, input int wd, input bit a, input int nfr);
    @(posedge clk); #3;
    cfg_half_len = 6'(hf); cfg_word_len = 5'(wd); cfg_msb_align = a; en = 1'b1;
    repeat (nfr * 4 * clamp_half(hf) + 8) @(posedge clk);
  endtask

  task automatic pause_link();
    @(posedge clk); #3;
    en = 1'b0;
    repeat (5) @(posedge clk);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h1f2e3d4c);
    rst_n = 1'b0; en = 1'b0; sdi = 1'b0;
    cfg_half_len = 6'd16; cfg_word_len = 5'd12; cfg_msb_align = 1'b0;
    tx_left = 16'hA5C3; tx_right = 16'h3C5A;
    repeat (3) @(posedge clk);
    #3;
    check(!sck && !ws && !sdo && !sdo_oe && !frame_irq, "R11 reset lines",
          {sck, ws, sdo, sdo_oe, frame_irq}, 0);
    check(rx_left == 16'h0 && rx_right == 16'h0, "R11 reset rx words",
          {rx_left, rx_right}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    run_cfg(16, 12, 1'b0, 3);
    run_cfg(16, 16, 1'b1, 3);   // word fills window at edge alignment
    run_cfg(16, 16, 1'b0, 3);   // R10: clamps to 15
    run_cfg(8, 7, 1'b0, 3);     // shortest half, full window
    run_cfg(8, 8, 1'b1, 3);
    run_cfg(8, 4, 1'b1, 3);
    run_cfg(32, 16, 1'b0, 3);   // longest half
    run_cfg(3, 20, 1'b0, 3);    // R10: half 8, word 7
    run_cfg(40, 2, 1'b1, 3);    // R10: half 32, word 4
    pause_link();               // R11: idle, then fresh start
    run_cfg(9, 5, 1'b0, 3);
    for (int i = 0; i < 16; i++) begin
      run_cfg(int'($urandom % 40), int'($urandom % 20), 1'($urandom), 2);
      if (i % 4 == 3) pause_link();
    end
    pause_link();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule